// File: doc/BRIEF.md
# Iterative 40-bit Multiply-Accumulate Unit

This block executes signed multiplies and multiply-accumulates on two 32-bit source operands. It also keeps a 40-bit accumulator register that software-visible operations can load from two general registers and read back as two 32-bit words. A single 16-by-32 signed multiplier array is reused across cycles. A short operand finishes in one pass. A full 32-bit multiplier needs a second pass, and the 64-bit-result form spends two more cycles on its upper word. Latency therefore depends on the operation and on the value of the second operand.

An operation is offered on a valid/ready issue port together with a destination tag. It moves through stages M1 to M5, one per cycle, and leaves the unit in the stage where it completes. At most two operations are inside at once. A new one may enter M1 only while the unit is empty, or while the youngest operation will complete in the next cycle. Operations that return a register value present it on the result port with their tag. A kill input cancels work that has not yet reached M3.

Top module: `mac_unit`

## Requirements
- R1: After the synchronous active-low reset, `in_ready` is high, `res_valid` is low and the accumulator holds zero.
- R2: `in_op` codes are: 0 = 16x32 multiply, 1 = 32x32 multiply (low word), 2 = 32x32 multiply (64-bit result), 3 = 16x32 multiply-accumulate, 4 = 32x32 multiply-accumulate, 5 = accumulator write, 6 = accumulator read. All multiplies are signed, and `in_b` is the multiplier.
- R3: No more than two accepted operations are in flight at any time.
- R4: `in_ready` is low while `kill` is high. Otherwise it is high when the unit is empty, or when the youngest in-flight operation completes in the next cycle; in all other cases it is low.
- R5: An operation accepted on a clock edge is in M1 during the next cycle and advances one stage per cycle. If it completes at stage Mk, its result appears during the k-th cycle after acceptance, counting the M1 cycle as the first.
- R6: Op 0 multiplies `in_a` by the signed 16-bit half of `in_b` chosen by `in_hi` (1 = bits 31:16, 0 = bits 15:0). It completes at M2, returns product bits 31:0 on `res_lo` with `res_hi` zero, and can be accepted on every cycle.
- R7: Op 1 returns bits 31:0 of `in_a*in_b` on `res_lo`, with `res_hi` zero. It completes at M2 when `in_b` lies in -32768..32767, and at M3 otherwise.
- R8: Op 2 returns the full signed 64-bit product, with low word on `res_lo` and high word on `res_hi`. It completes at M4 when `in_b` lies in -32768..32767, and at M5 otherwise.
- R9: Ops 3 and 4 add the signed product (as for ops 0 and 1) to the accumulator modulo 2^40. They take the same latency as ops 0 and 1, drive no result, and leave the accumulator unchanged in every cycle in which no accumulator write completes.
- R10: Op 5 completes at M2 and sets the accumulator to `{in_b[7:0], in_a}`, driving no result.
- R11: Op 6 completes at M2 with accumulator bits 31:0 on `res_lo` and bits 39:32 sign-extended on `res_hi`. It is not accepted while an op 3, 4 or 5 is in flight.
- R12: While `kill` is high, operations in M1 or M2 are dropped with no result and no accumulator change. Operations in M3 or later complete unaffected.
- R13: `res_tag` carries the `in_tag` given with the operation whose result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Issue accepted this cycle when high together with `in_valid` |
| in_op | input | 3 | Operation code (R2) |
| in_a | input | DATA_W | First source operand / accumulator low word |
| in_b | input | DATA_W | Multiplier / accumulator high byte in bits 7:0 |
| in_hi | input | 1 | Half select for 16-bit multiplier forms |
| in_tag | input | TAG_W | Destination tag |
| kill | input | 1 | Cancel operations in M1 and M2 |
| res_valid | output | 1 | Result present this cycle |
| res_tag | output | TAG_W | Tag of the result |
| res_lo | output | DATA_W | Result low word |
| res_hi | output | DATA_W | Result high word |

## Verification
The multiplier operand is driven with values well inside the 16-bit signed range, with the two range edges 0xFFFF8000 (fits) and 0x00008000 (does not fit), and with full-width random values. These patterns separate the one-pass and two-pass latencies and also check that the two partial products combine to the exact signed product. Back-to-back short operations, long operations followed by short ones, and accumulator reads issued directly behind accumulates tell apart the possible issue-ready patterns. The accumulator is preloaded just below the 2^39 and 2^40 boundaries, which shows the sign extension of the read-out high word and the modulo-2^40 wrap. Kill is raised at M1, at M2 and at M3, which separates dropped operations from committed ones.

// File: rtl/mac_pkg.sv
// Shared operation codes and per-operation properties for the MAC unit.
// Assumes a 3-bit operation field; code 7 is unused and acts as a no-op.
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL16  = 3'd0,
        OP_MUL32  = 3'd1,
        OP_MULL   = 3'd2,
        OP_MAC16  = 3'd3,
        OP_MAC32  = 3'd4,
        OP_ACCWR  = 3'd5,
        OP_ACCRD  = 3'd6
    } mac_op_e;

    // True for operations that drive the result port.
    function automatic logic op_has_result(mac_op_e op);
        return (op == OP_MUL16) || (op == OP_MUL32) || (op == OP_MULL) || (op == OP_ACCRD);
    endfunction

    // True for operations that change the accumulator.
    function automatic logic op_writes_acc(mac_op_e op);
        return (op == OP_MAC16) || (op == OP_MAC32) || (op == OP_ACCWR);
    endfunction

endpackage

// File: rtl/mac_decode.sv
// Splits the multiplier operand into one or two signed chunks for the
// 16x32 array and derives the stage in which the operation completes.
// Assumes DATA_W is even; chunks are CHUNK_W+1 bits, signed.
module mac_decode import mac_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]          op,
    input  logic [DATA_W-1:0]   b,
    input  logic                hi,
    output logic [DATA_W/2:0]   chunk0,
    output logic [DATA_W/2:0]   chunk1,
    output logic                two_pass,
    output logic [2:0]          done_stage
);
    localparam int CW = DATA_W / 2;

    logic [CW-1:0] half_sel;
    logic [CW:0]   upper_bits;
    logic          fits;

    // Chosen half for 16-bit forms; range test for the short 32-bit path.
    always_comb begin
        half_sel   = hi ? b[DATA_W-1:CW] : b[CW-1:0];
        upper_bits = b[DATA_W-1:CW-1];
        fits       = (&upper_bits) | ~(|upper_bits);
    end

    // Chunk selection and completion stage per operation.
    always_comb begin
        chunk0     = '0;
        chunk1     = {b[DATA_W-1], b[DATA_W-1:CW]};
        two_pass   = 1'b0;
        done_stage = 3'd2;
        case (mac_op_e'(op))
            OP_MUL16, OP_MAC16: chunk0 = {half_sel[CW-1], half_sel};
            OP_MUL32, OP_MAC32, OP_MULL: begin
                if (fits) begin
                    chunk0 = {b[CW-1], b[CW-1:0]};
                end else begin
                    chunk0   = {1'b0, b[CW-1:0]};
                    two_pass = 1'b1;
                end
                if (mac_op_e'(op) == OP_MULL) done_stage = fits ? 3'd4 : 3'd5;
                else                           done_stage = fits ? 3'd2 : 3'd3;
            end
            default: chunk0 = '0;
        endcase
    end
endmodule

// File: rtl/mac_array.sv
// One signed DATA_W by (DATA_W/2+1) multiplier array, shared over cycles.
// Purely combinational; the caller chooses which operation uses it.
module mac_array #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]          a,
    input  logic [DATA_W/2:0]          c,
    output logic [DATA_W+DATA_W/2:0]   pp
);
    localparam int CW = DATA_W / 2;
    localparam int PW = DATA_W + CW + 1;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] c_ext;

    // Sign-extend both operands to the product width, then multiply.
    always_comb begin
        a_ext = {{(PW-DATA_W){a[DATA_W-1]}}, a};
        c_ext = {{(PW-CW-1){c[CW]}}, c};
        pp    = a_ext * c_ext;
    end
endmodule

// File: rtl/mac_acc.sv
// Accumulator register with add and load, plus the two-word read view.
// Assumes DATA_W < ACC_W <= 2*DATA_W; add wraps modulo 2^ACC_W.
module mac_acc #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_en,
    input  logic                load_en,
    input  logic [ACC_W-1:0]    opnd,
    output logic [ACC_W-1:0]    acc_q,
    output logic [DATA_W-1:0]   rd_lo,
    output logic [DATA_W-1:0]   rd_hi
);
    localparam int EXT_W = 2 * DATA_W - ACC_W;

    // Accumulator state: load wins over add, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (load_en) acc_q <= opnd;
        else if (add_en)  acc_q <= acc_q + opnd;
    end

    // Read-out words: low word direct, upper bits sign-extended.
    always_comb begin
        rd_lo = acc_q[DATA_W-1:0];
        rd_hi = {{EXT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W]};
    end
endmodule

// File: rtl/mac_unit.sv
// Multiply / multiply-accumulate unit with a shared 16x32 array.
// Two slots: m1 holds an operation in its first cycle, xs holds the one
// in M2..M5. An operation enters m1 only if xs will be empty or retiring
// at the next edge, so the two slots never compete for the array.
// Assumes DATA_W = 32-style even width and DATA_W < ACC_W <= 2*DATA_W.
module mac_unit import mac_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40,
    parameter int TAG_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2:0]          in_op,
    input  logic [DATA_W-1:0]   in_a,
    input  logic [DATA_W-1:0]   in_b,
    input  logic                in_hi,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic                kill,
    output logic                res_valid,
    output logic [TAG_W-1:0]    res_tag,
    output logic [DATA_W-1:0]   res_lo,
    output logic [DATA_W-1:0]   res_hi
);
    localparam int CW    = DATA_W / 2;
    localparam int PW    = DATA_W + CW + 1;
    localparam int P64   = 2 * DATA_W;
    localparam int BH_W  = ACC_W - DATA_W;
    localparam int SW    = 3;

    // M1 slot
    logic                m1_v;
    mac_op_e             m1_op;
    logic [TAG_W-1:0]    m1_tag;
    logic [DATA_W-1:0]   m1_a;
    logic [BH_W-1:0]     m1_bh;
    logic [CW:0]         m1_c0, m1_c1;
    logic                m1_two;
    logic [SW-1:0]       m1_done;

    // Later-stage slot
    logic                x_v;
    mac_op_e             x_op;
    logic [TAG_W-1:0]    x_tag;
    logic [DATA_W-1:0]   x_a;
    logic [CW:0]         x_c1;
    logic                x_two;
    logic [SW-1:0]       x_stage, x_done;
    logic [P64-1:0]      x_p;

    // Decoded inputs, array and accumulator wiring
    logic [CW:0]         dec_c0, dec_c1;
    logic                dec_two;
    logic [SW-1:0]       dec_done;
    logic [DATA_W-1:0]   arr_a;
    logic [CW:0]         arr_c;
    logic [PW-1:0]       pp;
    logic [P64-1:0]      pp64, m1_payload;
    logic                x_final, x_killed, x_fire, accept;
    logic                youngest_ok, acc_busy;
    logic                acc_add, acc_load;
    logic [ACC_W-1:0]    acc_q;
    logic [DATA_W-1:0]   acc_rd_lo, acc_rd_hi;

    mac_decode #(.DATA_W(DATA_W)) u_decode (
        .op(in_op), .b(in_b), .hi(in_hi),
        .chunk0(dec_c0), .chunk1(dec_c1), .two_pass(dec_two), .done_stage(dec_done)
    );

    mac_array #(.DATA_W(DATA_W)) u_array (
        .a(arr_a), .c(arr_c), .pp(pp)
    );

    mac_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .add_en(acc_add), .load_en(acc_load),
        .opnd(x_p[ACC_W-1:0]), .acc_q(acc_q), .rd_lo(acc_rd_lo), .rd_hi(acc_rd_hi)
    );

    // Array user: the M1 operation's first chunk, else the M2 second chunk.
    always_comb begin
        arr_a      = m1_v ? m1_a  : x_a;
        arr_c      = m1_v ? m1_c0 : x_c1;
        pp64       = {{(P64-PW){pp[PW-1]}}, pp};
        m1_payload = (m1_op == OP_ACCWR) ? {{(P64-ACC_W){1'b0}}, m1_bh, m1_a} : pp64;
    end

    // Completion, kill and accumulator control for the later-stage slot.
    always_comb begin
        x_final  = x_v && (x_stage == x_done);
        x_killed = kill && x_v && (x_stage <= 3'd2);
        x_fire   = x_final && !x_killed;
        acc_add  = x_fire && ((x_op == OP_MAC16) || (x_op == OP_MAC32));
        acc_load = x_fire && (x_op == OP_ACCWR);
    end

    // Issue rule: empty, or youngest operation completes next cycle.
    always_comb begin
        youngest_ok = m1_v ? (m1_done == 3'd2) : (!x_v || (x_stage + 3'd1 == x_done));
        acc_busy    = (m1_v && op_writes_acc(m1_op)) || (x_v && op_writes_acc(x_op));
        in_ready    = !kill && youngest_ok && !((mac_op_e'(in_op) == OP_ACCRD) && acc_busy);
        accept      = in_valid && in_ready;
    end

    // M1 slot occupancy: each accepted operation stays exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) m1_v <= 1'b0;
        else        m1_v <= accept;
    end

    // M1 slot payload capture on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            m1_op   <= mac_op_e'(in_op);
            m1_tag  <= in_tag;
            m1_a    <= in_a;
            m1_bh   <= in_b[BH_W-1:0];
            m1_c0   <= dec_c0;
            m1_c1   <= dec_c1;
            m1_two  <= dec_two;
            m1_done <= dec_done;
        end
    end

    // Later-stage slot: take over from M1, advance, or retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_v <= 1'b0;
        end else if (m1_v && !kill) begin
            x_v     <= 1'b1;
            x_op    <= m1_op;
            x_tag   <= m1_tag;
            x_a     <= m1_a;
            x_c1    <= m1_c1;
            x_two   <= m1_two;
            x_stage <= 3'd2;
            x_done  <= m1_done;
            x_p     <= m1_payload;
        end else if (x_v && !x_final && !x_killed) begin
            x_stage <= x_stage + 3'd1;
            if (x_two && (x_stage == 3'd2)) x_p <= x_p + (pp64 << CW);
        end else begin
            x_v <= 1'b0;
        end
    end

    // Result port driven from the completing operation.
    always_comb begin
        res_valid = x_fire && op_has_result(x_op);
        res_tag   = x_tag;
        res_lo    = (x_op == OP_ACCRD) ? acc_rd_lo : x_p[DATA_W-1:0];
        case (x_op)
            OP_MULL:  res_hi = x_p[P64-1:DATA_W];
            OP_ACCRD: res_hi = acc_rd_hi;
            default:  res_hi = '0;
        endcase
    end
endmodule

// File: rtl/mac_unit_chk.sv
// Checker for mac_unit: slot ordering, stage progress, kill and
// accumulator hold properties. Attached by the bind below.
module mac_unit_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kill,
    input logic             m1_v,
    input logic             x_v,
    input logic [2:0]       x_stage,
    input logic [2:0]       x_done,
    input logic             acc_add,
    input logic             acc_load,
    input logic [ACC_W-1:0] acc_q
);
    // R4: a second operation sits only behind one in its final stage
    a_r4_pair_final: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_v && x_v) |-> (x_stage == x_done));

    // R5: completion stage stays within M2..M5 and is never passed
    a_r5_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
        x_v |-> ((x_done >= 3'd2) && (x_done <= 3'd5) && (x_stage <= x_done)));

    // R5: committed operations advance exactly one stage per cycle
    a_r5_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
        (x_v && (x_stage >= 3'd3) && (x_stage != x_done)) |=> (x_stage == $past(x_stage) + 3'd1));

    // R12: an operation at M3 or later survives a kill
    a_r12_commit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (x_v && (x_stage >= 3'd3) && (x_stage != x_done)) |=> x_v);

    // R12: kill with nothing committed leaves the unit empty
    a_r12_kill_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && (!x_v || (x_stage == 3'd2))) |=> (!m1_v && !x_v));

    // R9: the accumulator holds unless a write completes
    a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_add && !acc_load) |=> $stable(acc_q));
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W)) u_mac_unit_chk (
    .clk(clk), .rst_n(rst_n), .kill(kill), .m1_v(m1_v), .x_v(x_v),
    .x_stage(x_stage), .x_done(x_done), .acc_add(acc_add), .acc_load(acc_load),
    .acc_q(acc_q)
);

// File: tb/test_mac_unit.sv
// Bench for mac_unit: a queue-based reference model stepped once per
// cycle; every cycle compares ready and the result port against it.
module test_mac_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_hi = 1'b0, kill = 1'b0;
    logic [2:0]        in_op = 3'd0;
    logic [31:0]       in_a = '0, in_b = '0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic              in_ready, res_valid;
    logic [TAG_W-1:0]  res_tag;
    logic [31:0]       res_lo, res_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_unit #(.DATA_W(32), .ACC_W(40), .TAG_W(TAG_W)) i_mac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_hi(in_hi), .in_tag(in_tag),
        .kill(kill), .res_valid(res_valid), .res_tag(res_tag),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    typedef struct {
        int               op;
        int               age;
        int               done;
        logic [TAG_W-1:0] tag;
        logic [63:0]      prod;
        logic [39:0]      wval;
    } mop_t;

    mop_t        q[$];
    logic [39:0] m_acc = '0;
    int          checks = 0, fails = 0;
    bit          finished = 0;
    logic [TAG_W-1:0] next_tag = '0;
    logic [31:0] seed = 32'h1234_5679;

    function automatic int exp_done(int op, logic [31:0] b);
        bit fits = ($signed(b) >= -32768) && ($signed(b) <= 32767);
        case (op)
            1, 4:    return fits ? 2 : 3;
            2:       return fits ? 4 : 5;
            default: return 2;
        endcase
    endfunction

    function automatic logic [63:0] exp_prod(int op, logic [31:0] a, logic [31:0] b, bit hi);
        logic signed [63:0] sa = {{32{a[31]}}, a};
        logic signed [63:0] sb;
        logic [15:0] h = hi ? b[31:16] : b[15:0];
        if (op == 0 || op == 3) sb = {{48{h[15]}}, h};
        else                    sb = {{32{b[31]}}, b};
        return sa * sb;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R6";
            1: return "R7";
            2: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare outputs with the model, advance the model.
    task automatic step(input bit v, input int op, input logic [31:0] a, input logic [31:0] b,
                        input bit hi, input bit k, output bit acc);
        bit busy, er, ev;
        mop_t nq[$];
        mop_t m;
        @(negedge clk);
        in_valid = v; in_op = op[2:0]; in_a = a; in_b = b; in_hi = hi;
        in_tag = next_tag; kill = k;
        #1;
        busy = 0;
        foreach (q[i]) if (q[i].op inside {3, 4, 5}) busy = 1;
        er = !k && (q.size() == 0 || (q[$].age + 1 == q[$].done)) && !(op == 6 && busy);
        chk("R4", "in_ready", {63'b0, in_ready}, {63'b0, er});
        chk("R3", "in-flight <= 2", {63'b0, q.size() <= 2}, 64'd1);
        ev = (q.size() > 0) && (q[0].age == q[0].done) && !(k && q[0].age <= 2)
             && (q[0].op inside {0, 1, 2, 6});
        chk("R5", "res_valid", {63'b0, res_valid}, {63'b0, ev});
        if (ev && res_valid) begin
            chk("R13", "res_tag", {60'b0, res_tag}, {60'b0, q[0].tag});
            if (q[0].op == 6) begin
                chk("R11", "acc read lo", {32'b0, res_lo}, {32'b0, m_acc[31:0]});
                chk("R11", "acc read hi", {32'b0, res_hi}, {32'b0, {24{m_acc[39]}}, m_acc[39:32]});
            end else begin
                chk(req_of(q[0].op), "res_lo", {32'b0, res_lo}, {32'b0, q[0].prod[31:0]});
                chk(req_of(q[0].op), "res_hi", {32'b0, res_hi},
                    {32'b0, (q[0].op == 2) ? q[0].prod[63:32] : 32'b0});
            end
        end
        // R12: kill drops M1/M2; R9/R10 accumulator effects at completion
        foreach (q[i]) begin
            m = q[i];
            if (k && m.age <= 2) continue;
            if (m.age == m.done) begin
                if (m.op == 3 || m.op == 4) m_acc = m_acc + m.prod[39:0];
                else if (m.op == 5)         m_acc = m.wval;
            end else begin
                m.age++;
                nq.push_back(m);
            end
        end
        acc = v && er;
        if (acc) begin
            m.op = op; m.age = 1; m.done = exp_done(op, b); m.tag = next_tag;
            m.prod = exp_prod(op, a, b, hi); m.wval = {b[7:0], a};
            nq.push_back(m);
            next_tag++;
        end
        q = nq;
    endtask

    task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b, input bit hi);
        bit acc = 0;
        for (int n = 0; n < 20 && !acc; n++) step(1, op, a, b, hi, 0, acc);
    endtask

    task automatic idle(input int n, input bit k);
        bit acc;
        for (int i = 0; i < n; i++) step(0, 0, 32'd0, 32'd0, 0, k, acc);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        bit acc;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk("R1", "in_ready after reset", {63'b0, in_ready}, 64'd1);
        chk("R1", "res_valid after reset", {63'b0, res_valid}, 64'd0);
        issue(6, 0, 0, 0);                         // R1: accumulator reads zero
        idle(2, 0);
        // R6: both halves, then back-to-back (codes per R2)
        issue(0, 32'hFFFF_FFFD, 32'h0007_FFF0, 0);
        issue(0, 32'hFFFF_FFFD, 32'hFFEB_0000, 1);
        for (int i = 0; i < 6; i++) issue(0, 32'h0001_0000 + i, 32'h8000_7FFF, i[0]);
        idle(3, 0);
        // R7: short, long, and the two range edges
        issue(1, 32'd1000, 32'hFFFF_F830, 0);
        issue(1, 32'h7654_3210, 32'h0001_2345, 0);
        issue(1, 32'h0000_0003, 32'h0000_8000, 0);
        issue(1, 32'h0000_0003, 32'hFFFF_8000, 0);
        idle(4, 0);
        // R8: long and short 64-bit forms
        issue(2, 32'h8000_0000, 32'h8000_0000, 0);
        issue(2, 32'hFFFF_FFFF, 32'h0000_0005, 0);
        issue(0, 32'd7, 32'd9, 0);
        idle(6, 0);
        // R10/R9: load near 2^39, accumulate across, read (R11 stall behind MAC)
        issue(5, 32'hFFFF_FFFF, 32'h0000_007F, 0);
        issue(3, 32'd1, 32'd1, 0);
        issue(6, 0, 0, 0);
        issue(5, 32'hFFFF_FFFF, 32'h0000_00FF, 0);
        issue(4, 32'd2, 32'h0001_0000, 0);         // wraps modulo 2^40
        issue(6, 0, 0, 0);
        idle(3, 0);
        // R12: kill at M1, at M2, and at M3 (committed)
        issue(1, 32'h1111_1111, 32'h2222_2222, 0); idle(1, 1);
        issue(1, 32'h1111_1111, 32'h2222_2222, 0); idle(1, 0); idle(1, 1);
        issue(2, 32'h1234_5678, 32'h8765_4321, 0); idle(2, 0); idle(1, 1);
        idle(3, 0);
        issue(3, 32'd100, 32'd100, 0); idle(1, 0); idle(1, 1);
        issue(6, 0, 0, 0);
        idle(3, 0);
        // Mixed random traffic with kills and range-edge multipliers
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            r = seed;
            case (r[3:2])
                2'd0: b = {{16{r[31]}}, r[31:16]};
                2'd1: b = r ^ 32'h5A5A_A5A5;
                2'd2: b = 32'h0000_8000;
                default: b = 32'hFFFF_8000;
            endcase
            step(r[5:4] != 2'd0, int'(r[15:8]) % 7, {r[7:0], r[31:8]}, b, r[6],
                 r[21:18] == 4'd0, acc);
        end
        idle(8, 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule